// File: doc/BRIEF.md
# Indexed Byte Window with Region Locks

This block gives a host a four-byte I/O window onto a byte-wide memory of up to 64 KiB held inside the block. The host first loads a 16-bit address pointer through two pointer offsets, one for the low byte and one for the high byte. It then moves one byte at a time through a data offset. A store through the data offset sets the pointer back to zero, so every store must name its address again. A load leaves the pointer where it was, so the same byte can be read repeatedly.

Two protection bits each guard a fixed 16-byte span of memory, 0x20..0x2F and 0x30..0x3F. While a span is guarded, loads from it return 0xFF and stores into it are discarded. A separate toggle request flips one protection bit, chosen by number. Addresses at or beyond the memory size behave like guarded ones. Because the memory is synchronous, every read returns its byte one cycle after the strobe, together with a valid flag.

Top module: `nvwin_port`

## Requirements
- R1: A write at offset 0 replaces pointer bits 7:0. A write at offset 1 replaces pointer bits 15:8. The other pointer byte keeps its value in both cases.
- R2: A write at offset 3 stores the byte at the pointed address, and the pointer becomes 0x0000 in the next cycle. The pointer is cleared even when the store itself is dropped.
- R3: A read at offset 3 returns the byte at the pointed address and leaves the pointer unchanged.
- R4: Reads at offsets 0, 1 and 2 return 0xFF. A write at offset 2 changes neither the pointer nor the memory.
- R5: While protection bit 0 is 1, addresses 0x20..0x2F are guarded. While protection bit 1 is 1, addresses 0x30..0x3F are guarded. A guarded read returns 0xFF and a guarded store is discarded.
- R6: A cycle with `lock_tgl`=1 inverts the protection bit numbered by `lock_sel` and leaves the other bit alone.
- R7: Reset clears both protection bits and the pointer. Memory contents survive reset.
- R8: A pointer at or above MEM_BYTES reads as 0xFF and drops stores. Such an address does not alias onto a lower one.
- R9: `rd_valid` is 1 exactly in the cycle after each cycle with `host_rd`=1, and `rd_data` is valid while it is 1.
- R10: An access in the same cycle as a toggle is judged against the protection state before the toggle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_off | input | 2 | Window offset: 0 pointer low, 1 pointer high, 2 spare, 3 data |
| host_wdata | input | DW | Write byte |
| host_wr | input | 1 | Write strobe |
| host_rd | input | 1 | Read strobe |
| lock_tgl | input | 1 | Toggle request for one protection bit |
| lock_sel | input | SELW | Number of the protection bit to toggle |
| rd_data | output | DW | Read byte, valid while rd_valid is 1 |
| rd_valid | output | 1 | Read result strobe, one cycle after host_rd |

## Verification
A protection toggle and a data access can land in the same cycle. The access then has to see the protection state from before the toggle. The bench raises `lock_tgl` together with a read strobe into a span that is unguarded at that moment, and expects the stored byte back. A read that follows expects 0xFF. The bench repeats this with a store into a span that is guarded at that moment: the stored byte must stay unchanged after the toggle has removed the guard.

// File: rtl/nvwin_pkg.sv
package nvwin_pkg;

  typedef enum logic [1:0] {
    WIN_ADDR_LO = 2'd0,
    WIN_ADDR_HI = 2'd1,
    WIN_SPARE   = 2'd2,
    WIN_DATA    = 2'd3
  } win_off_e;

  localparam logic [7:0] IDLE_BYTE = 8'hFF;

  // half-open span test [lo, lo+n)
  function automatic logic in_span(input logic [31:0] a, input logic [31:0] lo,
                                   input logic [31:0] n);
    return (a >= lo) && (a < lo + n);
  endfunction

  function automatic logic below_size(input logic [31:0] a, input logic [31:0] size);
    return a < size;
  endfunction

endpackage

// File: rtl/nvwin_addr_reg.sv
module nvwin_addr_reg #(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld_lo,
  input  logic          ld_hi,
  input  logic          clr,
  input  logic [DW-1:0] din,
  output logic [AW-1:0] addr
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr <= '0;
    end else if (clr) begin
      addr <= '0;
    end else begin
      if (ld_lo) addr[DW-1:0]  <= din;
      if (ld_hi) addr[AW-1:DW] <= din[AW-DW-1:0];
    end
  end
endmodule

// File: rtl/nvwin_lock_bits.sv
module nvwin_lock_bits
  import nvwin_pkg::*;
#(
  parameter int AW        = 16,
  parameter int NLOCK     = 2,
  parameter int SELW      = 1,
  parameter int LOCK_BASE = 32,
  parameter int LOCK_SPAN = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tgl,
  input  logic [SELW-1:0]  sel,
  input  logic [AW-1:0]    addr,
  output logic [NLOCK-1:0] lock_q,
  output logic             blocked
);
  logic [NLOCK-1:0] hit;

  for (genvar i = 0; i < NLOCK; i++) begin : g_lock
    localparam logic [31:0] LO = 32'(LOCK_BASE + i * LOCK_SPAN);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                         lock_q[i] <= 1'b0;
      else if (tgl && sel == SELW'(i))    lock_q[i] <= ~lock_q[i];
    end
    assign hit[i] = lock_q[i] && in_span(32'(addr), LO, 32'(LOCK_SPAN));
  end

  assign blocked = |hit;
endmodule

// File: rtl/nvwin_mem.sv
module nvwin_mem #(
  parameter int DEPTH = 256,
  parameter int DW    = 8,
  localparam int IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          we,
  input  logic [IW-1:0] widx,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [IW-1:0] ridx,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (we) store[widx] <= wdata;
    if (re) rdata <= store[ridx];
  end
endmodule

// File: rtl/nvwin_port.sv
module nvwin_port
  import nvwin_pkg::*;
#(
  parameter int MEM_BYTES = 256,
  parameter int AW        = 16,
  parameter int DW        = 8,
  parameter int NLOCK     = 2,
  parameter int LOCK_BASE = 32,
  parameter int LOCK_SPAN = 16,
  localparam int SELW     = (NLOCK > 1) ? $clog2(NLOCK) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [1:0]      host_off,
  input  logic [DW-1:0]   host_wdata,
  input  logic            host_wr,
  input  logic            host_rd,
  input  logic            lock_tgl,
  input  logic [SELW-1:0] lock_sel,
  output logic [DW-1:0]   rd_data,
  output logic            rd_valid
);
  localparam int IW = (MEM_BYTES > 1) ? $clog2(MEM_BYTES) : 1;

  // named internal events, also watched by the checker
  logic [AW-1:0]    addr_q;
  logic [NLOCK-1:0] lock_q;
  logic             blocked;
  logic             in_range;
  logic             access_ok;
  logic             data_wr;
  logic             data_rd;
  logic             mem_we;
  logic             mem_re;
  logic [DW-1:0]    mem_rdata;
  logic             rd_ok_q;

  assign data_wr   = host_wr && (host_off == WIN_DATA);
  assign data_rd   = host_rd && (host_off == WIN_DATA);
  assign in_range  = below_size(32'(addr_q), 32'(MEM_BYTES));
  assign access_ok = in_range && !blocked;
  assign mem_we    = data_wr && access_ok;
  assign mem_re    = data_rd && access_ok;

  nvwin_addr_reg #(.AW(AW), .DW(DW)) u_addr (
    .clk   (clk),
    .rst_n (rst_n),
    .ld_lo (host_wr && (host_off == WIN_ADDR_LO)),
    .ld_hi (host_wr && (host_off == WIN_ADDR_HI)),
    .clr   (data_wr),
    .din   (host_wdata),
    .addr  (addr_q)
  );

  nvwin_lock_bits #(
    .AW(AW), .NLOCK(NLOCK), .SELW(SELW),
    .LOCK_BASE(LOCK_BASE), .LOCK_SPAN(LOCK_SPAN)
  ) u_lock (
    .clk     (clk),
    .rst_n   (rst_n),
    .tgl     (lock_tgl),
    .sel     (lock_sel),
    .addr    (addr_q),
    .lock_q  (lock_q),
    .blocked (blocked)
  );

  nvwin_mem #(.DEPTH(MEM_BYTES), .DW(DW)) u_mem (
    .clk   (clk),
    .we    (mem_we),
    .widx  (addr_q[IW-1:0]),
    .wdata (host_wdata),
    .re    (mem_re),
    .ridx  (addr_q[IW-1:0]),
    .rdata (mem_rdata)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_ok_q  <= 1'b0;
    end else begin
      rd_valid <= host_rd;
      rd_ok_q  <= mem_re;
    end
  end

  assign rd_data = rd_ok_q ? mem_rdata : DW'(IDLE_BYTE);
endmodule

// File: rtl/nvwin_chk.sv
module nvwin_chk #(
  parameter int AW        = 16,
  parameter int DW        = 8,
  parameter int NLOCK     = 2,
  parameter int SELW      = 1,
  parameter int LOCK_BASE = 32,
  parameter int LOCK_SPAN = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       host_off,
  input logic             host_wr,
  input logic             host_rd,
  input logic             lock_tgl,
  input logic [SELW-1:0]  lock_sel,
  input logic [DW-1:0]    rd_data,
  input logic             rd_valid,
  input logic [AW-1:0]    addr_q,
  input logic [NLOCK-1:0] lock_q,
  input logic             mem_we
);
  // R2
  addr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && host_off == 2'd3) |=> (addr_q == '0));

  // R3
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd && !host_wr) |=> (addr_q == $past(addr_q)));

  // R4
  spare_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd && host_off != 2'd3) |=> (rd_data == {DW{1'b1}}));

  // R9
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    host_rd |=> rd_valid);

  // R9
  valid_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !host_rd |=> !rd_valid);

  for (genvar i = 0; i < NLOCK; i++) begin : g_chk
    localparam int LO = LOCK_BASE + i * LOCK_SPAN;
    localparam int HI = LO + LOCK_SPAN;
    // R6
    lock_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (lock_tgl && lock_sel == SELW'(i)) |=> (lock_q[i] != $past(lock_q[i])));
    // R6
    lock_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(lock_tgl && lock_sel == SELW'(i)) |=> $stable(lock_q[i]));
    // R5
    lock_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_we && lock_q[i]) |-> !(32'(addr_q) >= 32'(LO) && 32'(addr_q) < 32'(HI)));
  end
endmodule

bind nvwin_port nvwin_chk #(
  .AW(AW), .DW(DW), .NLOCK(NLOCK), .SELW(SELW),
  .LOCK_BASE(LOCK_BASE), .LOCK_SPAN(LOCK_SPAN)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .host_off (host_off),
  .host_wr  (host_wr),
  .host_rd  (host_rd),
  .lock_tgl (lock_tgl),
  .lock_sel (lock_sel),
  .rd_data  (rd_data),
  .rd_valid (rd_valid),
  .addr_q   (addr_q),
  .lock_q   (lock_q),
  .mem_we   (mem_we)
);

// File: tb/sim_nvwin_port.sv
module sim_nvwin_port;
  localparam int MEMB = 256;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] host_off = '0;
  logic [7:0] host_wdata = '0;
  logic       host_wr = 1'b0;
  logic       host_rd = 1'b0;
  logic       lock_tgl = 1'b0;
  logic [0:0] lock_sel = '0;
  logic [7:0] rd_data;
  logic       rd_valid;

  int vectors = 0;
  int miscompares = 0;
  int cycles = 0;
  bit done = 0;

  logic [7:0] exp_mem [MEMB];
  bit         lk [2];

  always #5 clk = ~clk;

  nvwin_port #(.MEM_BYTES(MEMB)) u0 (
    .clk(clk), .rst_n(rst_n), .host_off(host_off), .host_wdata(host_wdata),
    .host_wr(host_wr), .host_rd(host_rd), .lock_tgl(lock_tgl), .lock_sel(lock_sel),
    .rd_data(rd_data), .rd_valid(rd_valid)
  );

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000 && !done) begin
      miscompares = miscompares + 1;
      $display("FAIL watchdog: got %0d cycles expected fewer", cycles);
      summary();
    end
  end

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: got %02h expected %02h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input int a);
    return 8'((a * 37 + 11) ^ (a >> 3));
  endfunction

  // expected byte for an address, from the requirements (R5, R8)
  function automatic logic [7:0] exp_rd(input int a);
    if (a >= MEMB) return 8'hFF;
    if (lk[0] && a >= 32'h20 && a <= 32'h2F) return 8'hFF;
    if (lk[1] && a >= 32'h30 && a <= 32'h3F) return 8'hFF;
    return exp_mem[a];
  endfunction

  task automatic wr(input logic [1:0] off, input logic [7:0] d);
    @(negedge clk);
    host_off = off; host_wdata = d; host_wr = 1'b1;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] off, output logic [7:0] d, output logic v);
    @(negedge clk);
    host_off = off; host_rd = 1'b1;
    @(negedge clk);
    d = rd_data; v = rd_valid;
    host_rd = 1'b0;
  endtask

  task automatic set_addr(input int a);
    wr(2'd0, 8'(a));
    wr(2'd1, 8'(a >> 8));
  endtask

  task automatic rd_chk(input string tag, input logic [1:0] off, input logic [7:0] exp);
    logic [7:0] d;
    logic v;
    rd(off, d, v);
    check({tag, " data"}, d, exp);
    check("R9 valid", {7'd0, v}, 8'd1);
  endtask

  // store through the window and model the result (R2, R5, R8)
  task automatic poke(input int a, input logic [7:0] d);
    set_addr(a);
    wr(2'd3, d);
    if (a < MEMB && exp_rd(a) == exp_mem[a] &&
        !(lk[0] && a >= 32'h20 && a <= 32'h2F) &&
        !(lk[1] && a >= 32'h30 && a <= 32'h3F))
      exp_mem[a] = d;
  endtask

  task automatic toggle(input int s);
    @(negedge clk);
    lock_tgl = 1'b1; lock_sel = 1'(s);
    @(negedge clk);
    lock_tgl = 1'b0;
    lk[s] = !lk[s];
  endtask

  task automatic pulse_reset();
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    lk[0] = 0; lk[1] = 0;
  endtask

  initial begin
    logic [7:0] d;
    logic v;
    lk[0] = 0; lk[1] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R7: reset state at the ports
    check("R7 reset rd_valid", {7'd0, rd_valid}, 8'd0);
    check("R7 reset rd_data", rd_data, 8'hFF);

    // R2 / R3: full sweep, store then read back every byte
    for (int a = 0; a < MEMB; a++) poke(a, pat(a));
    for (int a = 0; a < MEMB; a++) begin
      set_addr(a);
      rd_chk("R3 sweep", 2'd3, exp_rd(a));
    end

    // R2: pointer returns to zero after a store
    poke(32'h77, 8'h5A);
    rd_chk("R2 pointer cleared", 2'd3, exp_mem[0]);
    // R3: repeated read keeps pointer
    set_addr(32'h66);
    rd_chk("R3 first read", 2'd3, exp_mem[32'h66]);
    rd_chk("R3 second read", 2'd3, exp_mem[32'h66]);

    // R1: byte-wise pointer loads
    wr(2'd0, 8'h42);
    wr(2'd1, 8'h01);
    rd_chk("R8 pointer 0x0142", 2'd3, 8'hFF);
    wr(2'd1, 8'h00);
    rd_chk("R1 high byte replaced", 2'd3, exp_mem[32'h42]);
    wr(2'd0, 8'h99);
    rd_chk("R1 low byte replaced", 2'd3, exp_mem[32'h99]);

    // R8: out-of-range stores do not alias
    poke(32'h0110, 8'hEE);
    rd_chk("R2 cleared after dropped store", 2'd3, exp_mem[0]);
    set_addr(32'h10);
    rd_chk("R8 no alias 0x10", 2'd3, exp_mem[32'h10]);
    poke(32'hFFFF, 8'h11);
    set_addr(32'hFF);
    rd_chk("R8 no alias 0xFF", 2'd3, exp_mem[32'hFF]);
    set_addr(32'h8000);
    rd_chk("R8 read 0x8000", 2'd3, 8'hFF);

    // R4: non-data offsets
    set_addr(32'h50);
    rd_chk("R4 read off0", 2'd0, 8'hFF);
    rd_chk("R4 read off1", 2'd1, 8'hFF);
    rd_chk("R4 read off2", 2'd2, 8'hFF);
    wr(2'd2, 8'h3C);
    rd_chk("R4 spare write ignored", 2'd3, exp_mem[32'h50]);

    // R5 / R6: all four lock states, sweep around both spans
    for (int st = 0; st < 4; st++) begin
      if (st == 1) toggle(0);
      if (st == 2) begin toggle(0); toggle(1); end
      if (st == 3) toggle(0);
      poke(32'h20, 8'hA0 + 8'(st));
      poke(32'h2F, 8'hB0 + 8'(st));
      poke(32'h30, 8'hC0 + 8'(st));
      poke(32'h3F, 8'hD0 + 8'(st));
      for (int a = 32'h18; a < 32'h48; a++) begin
        set_addr(a);
        rd_chk("R5 lock sweep", 2'd3, exp_rd(a));
      end
    end
    toggle(0);
    toggle(1);
    for (int a = 32'h20; a < 32'h40; a++) begin
      set_addr(a);
      rd_chk("R6 unlocked readback", 2'd3, exp_rd(a));
    end

    // R10: toggle together with a read; access sees the old (unlocked) state
    set_addr(32'h22);
    @(negedge clk);
    host_off = 2'd3; host_rd = 1'b1; lock_tgl = 1'b1; lock_sel = 1'b0;
    @(negedge clk);
    d = rd_data; v = rd_valid;
    host_rd = 1'b0; lock_tgl = 1'b0;
    check("R10 read with toggle", d, exp_mem[32'h22]);
    check("R9 valid with toggle", {7'd0, v}, 8'd1);
    lk[0] = 1;
    rd_chk("R10 read after toggle", 2'd3, 8'hFF);
    // R10: toggle together with a store into a guarded span; store dropped
    set_addr(32'h24);
    @(negedge clk);
    host_off = 2'd3; host_wdata = 8'h77; host_wr = 1'b1; lock_tgl = 1'b1; lock_sel = 1'b0;
    @(negedge clk);
    host_wr = 1'b0; lock_tgl = 1'b0;
    lk[0] = 0;
    set_addr(32'h24);
    rd_chk("R10 store with toggle dropped", 2'd3, exp_mem[32'h24]);

    // R7: reset mid-run clears pointer and locks, keeps memory
    toggle(1);
    set_addr(32'h35);
    rd_chk("R5 span1 locked", 2'd3, 8'hFF);
    pulse_reset();
    rd_chk("R7 pointer cleared by reset", 2'd3, exp_mem[0]);
    set_addr(32'h35);
    rd_chk("R7 lock cleared by reset", 2'd3, exp_mem[32'h35]);

    // R9: idle cycle gives no valid
    @(negedge clk);
    @(negedge clk);
    check("R9 idle no valid", {7'd0, rd_valid}, 8'd0);

    done = 1;
    summary();
  end
endmodule